// File: doc/BRIEF.md
# Converter Mode and Protection Supervisor

This block chooses how a boost converter with a bypass switch operates. It also decides when the power switches must be held off and what the power-good pin shows. Two pins drive the choice: an enable pin and an active-low bypass request pin. A two-bit software field can override the pins. The bypass request is trusted only after enable has been high for a programmable number of clock cycles. This follows the rule that the bypass request may be honoured only after enable has been high for more than 60 µs.

Analog comparators and a temperature sensor feed the block. It does not contain them. The comparators supply four input-voltage flags, and the sensor supplies an unsigned die temperature in whole degrees Celsius. Input undervoltage, input overvoltage and over-temperature each have a set/reset hysteresis latch, and any one of them forces both switch groups off. A separate hot-die latch, together with the valley-overcurrent flag and the soft-start sequencer, decides whether power-good is released. Power-good drives an open-drain pin, so it is brought out as a pull-low command.

Top module: `converter_mode_supervisor`

## Requirements
- R1: While `en_pin` is low, the next cycle shows mode shutdown (2'b00) with `out_discharge` high, whatever `nbyp_pin` and `sw_override` are.
- R2: With `sw_override`=00 and `en_pin` high, a high `nbyp_pin` is treated as low until `en_pin` has been sampled high on QUAL_CYCLES consecutive clock edges.
- R3: With `sw_override`=00, the pins decide the mode. `en_pin` high with a low (or not yet trusted) `nbyp_pin` gives forced pass-through (2'b01). `en_pin` high with a trusted high `nbyp_pin` gives auto.
- R4: While `en_pin` is high, `sw_override` decides the mode whatever `nbyp_pin` is. 01 gives auto, 10 gives forced pass-through, and 11 gives shutdown.
- R5: In auto, the mode is auto-bypass (2'b11) when `vin_above_target` is high, and auto-boost (2'b10) otherwise.
- R6: `vin_below_uv` sets the undervoltage latch and `vin_above_uvrel` clears it. The latch holds while neither flag is high, and it comes out of reset set.
- R7: `vin_above_ov` sets the overvoltage latch and `vin_below_ovrel` clears it. The latch holds while neither flag is high.
- R8: `die_temp` at or above OTP_TRIP (160) sets the over-temperature latch. At or below OTP_REL (140) it clears the latch.
- R9: A set undervoltage, overvoltage or over-temperature latch makes the next outputs show both `boost_gate_off` and `bypass_gate_off` high. Outside a fault, the boost switch runs only in auto-boost and the bypass switch only in pass-through or auto-bypass.
- R10: In auto, `pgood_pull_low` is low only in these conditions together:
  - `softstart_done` is high;
  - there is no fault;
  - `valley_oc` is low;
  - the hot-die latch is clear. That latch is set at or above HOT_TRIP (121) and cleared at or below HOT_REL (99).
- R11: In forced pass-through, `pgood_pull_low` is low unless a fault is latched. In shutdown, it is always high.
- R12: Reset gives mode shutdown, both gate-off commands high, discharge high and power-good pulled low.
- R13: Each output is registered. It reflects the pins one cycle later, and a voltage or temperature flag two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable pin |
| nbyp_pin | input | 1 | Active-low bypass request pin |
| sw_override | input | 2 | Software mode override |
| vin_below_uv | input | 1 | Input below the undervoltage trip level |
| vin_above_uvrel | input | 1 | Input above the undervoltage release level |
| vin_above_ov | input | 1 | Input above the overvoltage trip level |
| vin_below_ovrel | input | 1 | Input below the overvoltage release level |
| die_temp | input | TEMP_W | Die temperature code, in °C |
| valley_oc | input | 1 | Valley overcurrent limit active |
| softstart_done | input | 1 | Soft-start sequence complete |
| vin_above_target | input | 1 | Input above the output target |
| mode | output | 2 | 00 shutdown, 01 pass-through, 10 auto-boost, 11 auto-bypass |
| boost_gate_off | output | 1 | Hold the boost switches off |
| bypass_gate_off | output | 1 | Hold the bypass switch off |
| out_discharge | output | 1 | Discharge the output |
| pgood_pull_low | output | 1 | Pull the open-drain power-good pin low |

## Verification
A latched protection and a mode change can arrive in the same cycle. For example, an overvoltage flag can rise while the bench moves from auto to forced pass-through, or a temperature step can cross the trip level while the input crosses the target. When that happens, the gate-off commands must follow the fault latch and not the new mode, and power-good must follow the pass-through rule in which only a fault counts. The bench provokes these overlaps by changing pins, override and flags on the same edge. A behavioural model predicts every output on every clock, so the gating and power-good result of each overlap is judged cycle by cycle.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    MODE_SHDN   = 2'b00,
    MODE_PASS   = 2'b01,
    MODE_BOOST  = 2'b10,
    MODE_BYPASS = 2'b11
  } cms_mode_e;

  typedef enum logic [1:0] {
    OVR_PINS = 2'b00,
    OVR_AUTO = 2'b01,
    OVR_PASS = 2'b10,
    OVR_SHDN = 2'b11
  } cms_ovr_e;
endpackage

// File: rtl/cms_enable_qualifier.sv
module cms_enable_qualifier #(
  parameter int QUAL_CYCLES = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = !en_i || (cnt_q != LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)              cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual_o = (cnt_q == LIMIT);

  // R2: trust only follows a run of enable-high edges
  a_r2_qual_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    qual_o |-> $past(en_i));
  a_r2_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !qual_o);
endmodule

// File: rtl/cms_hyst_latch.sv
module cms_hyst_latch #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d, q_en;

  assign q_en = set_i || clr_i;
  assign q_d  = set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST_VAL;
    else if (q_en) q_o <= q_d;
  end

  // R6 R7 R8 R10: set dominates, clear releases, otherwise hold
  a_r6_hyst_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r6_hyst_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r6_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/cms_mode_decode.sv
module cms_mode_decode
  import cms_pkg::*;
(
  input  logic      en_i,
  input  logic      nbyp_qual_i,
  input  logic [1:0] ovr_i,
  input  logic      above_target_i,
  output cms_mode_e mode_o
);
  logic want_auto;

  always_comb begin
    want_auto = 1'b0;
    mode_o    = MODE_SHDN;
    if (en_i) begin
      unique case (cms_ovr_e'(ovr_i))
        OVR_PINS: begin want_auto = nbyp_qual_i; mode_o = MODE_PASS; end
        OVR_AUTO: want_auto = 1'b1;
        OVR_PASS: mode_o = MODE_PASS;
        OVR_SHDN: mode_o = MODE_SHDN;
        default:  mode_o = MODE_SHDN;
      endcase
      if (want_auto) mode_o = above_target_i ? MODE_BYPASS : MODE_BOOST;
    end
  end
endmodule

// File: rtl/converter_mode_supervisor.sv
module converter_mode_supervisor
  import cms_pkg::*;
#(
  parameter int QUAL_CYCLES = 6000,
  parameter int TEMP_W      = 8,
  parameter int OTP_TRIP    = 160,
  parameter int OTP_REL     = 140,
  parameter int HOT_TRIP    = 121,
  parameter int HOT_REL     = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin,
  input  logic              nbyp_pin,
  input  logic [1:0]        sw_override,
  input  logic              vin_below_uv,
  input  logic              vin_above_uvrel,
  input  logic              vin_above_ov,
  input  logic              vin_below_ovrel,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic              valley_oc,
  input  logic              softstart_done,
  input  logic              vin_above_target,
  output logic [1:0]        mode,
  output logic              boost_gate_off,
  output logic              bypass_gate_off,
  output logic              out_discharge,
  output logic              pgood_pull_low
);
  localparam logic [TEMP_W-1:0] OTP_TRIP_C = TEMP_W'(OTP_TRIP);
  localparam logic [TEMP_W-1:0] OTP_REL_C  = TEMP_W'(OTP_REL);
  localparam logic [TEMP_W-1:0] HOT_TRIP_C = TEMP_W'(HOT_TRIP);
  localparam logic [TEMP_W-1:0] HOT_REL_C  = TEMP_W'(HOT_REL);
  localparam int NPROT = 4;

  logic             nbyp_qual, en_qual;
  logic [NPROT-1:0] prot_set, prot_clr, prot_q;
  logic             uv_q, ov_q, otp_q, hot_q, fault;
  cms_mode_e        mode_d;
  logic             boost_off_d, bypass_off_d, pg_d;

  cms_enable_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .en_i(en_pin), .qual_o(en_qual)
  );
  assign nbyp_qual = nbyp_pin && en_qual;

  assign prot_set = {die_temp >= HOT_TRIP_C, die_temp >= OTP_TRIP_C,
                     vin_above_ov, vin_below_uv};
  assign prot_clr = {die_temp <= HOT_REL_C, die_temp <= OTP_REL_C,
                     vin_below_ovrel, vin_above_uvrel};

  for (genvar gi = 0; gi < NPROT; gi++) begin : g_prot
    cms_hyst_latch #(.RST_VAL(gi == 0)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .set_i(prot_set[gi]), .clr_i(prot_clr[gi]), .q_o(prot_q[gi])
    );
  end
  assign {hot_q, otp_q, ov_q, uv_q} = prot_q;
  assign fault = uv_q || ov_q || otp_q;

  cms_mode_decode u_dec (
    .en_i(en_pin), .nbyp_qual_i(nbyp_qual), .ovr_i(sw_override),
    .above_target_i(vin_above_target), .mode_o(mode_d)
  );

  always_comb begin
    boost_off_d  = fault || (mode_d != MODE_BOOST);
    bypass_off_d = fault || !((mode_d == MODE_PASS) || (mode_d == MODE_BYPASS));
    unique case (mode_d)
      MODE_PASS:   pg_d = !fault;
      MODE_BOOST,
      MODE_BYPASS: pg_d = softstart_done && !fault && !valley_oc && !hot_q;
      default:     pg_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode            <= MODE_SHDN;
      boost_gate_off  <= 1'b1;
      bypass_gate_off <= 1'b1;
      out_discharge   <= 1'b1;
      pgood_pull_low  <= 1'b1;
    end else begin
      mode            <= mode_d;
      boost_gate_off  <= boost_off_d;
      bypass_gate_off <= bypass_off_d;
      out_discharge   <= !en_pin;
      pgood_pull_low  <= !pg_d;
    end
  end

  // R1: enable low forces shutdown and discharge
  a_r1_shdn_on_en_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_pin) |-> (mode == MODE_SHDN) && out_discharge);
  // R9: any latched fault opens every switch on the next cycle
  a_r9_fault_gates: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (boost_gate_off && bypass_gate_off));
  a_r9_boost_only_in_boost: assert property (@(posedge clk) disable iff (!rst_n)
    !boost_gate_off |-> (mode == MODE_BOOST));
  a_r9_never_both_on: assert property (@(posedge clk) disable iff (!rst_n)
    boost_gate_off || bypass_gate_off);
  // R11: shutdown always pulls power-good low
  a_r11_pg_low_in_shdn: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHDN) |-> pgood_pull_low);
endmodule

// File: tb/converter_mode_supervisor_tb.sv
module converter_mode_supervisor_tb;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 0, nbyp_pin = 0;
  logic [1:0] sw_override = 2'b00;
  logic vin_below_uv = 0, vin_above_uvrel = 0, vin_above_ov = 0, vin_below_ovrel = 1;
  logic [7:0] die_temp = 8'd25;
  logic valley_oc = 0, softstart_done = 0, vin_above_target = 0;
  logic [1:0] mode;
  logic boost_gate_off, bypass_gate_off, out_discharge, pgood_pull_low;

  always #5 clk = ~clk;

  converter_mode_supervisor #(.QUAL_CYCLES(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .nbyp_pin(nbyp_pin),
    .sw_override(sw_override), .vin_below_uv(vin_below_uv),
    .vin_above_uvrel(vin_above_uvrel), .vin_above_ov(vin_above_ov),
    .vin_below_ovrel(vin_below_ovrel), .die_temp(die_temp),
    .valley_oc(valley_oc), .softstart_done(softstart_done),
    .vin_above_target(vin_above_target), .mode(mode),
    .boost_gate_off(boost_gate_off), .bypass_gate_off(bypass_gate_off),
    .out_discharge(out_discharge), .pgood_pull_low(pgood_pull_low)
  );

  int checks = 0, failures = 0;
  string tag = "R12";
  bit done = 0;

  // behavioural reference model
  int m_cnt, m_uv, m_ov, m_otp, m_hot;
  int e_mode, e_boff, e_byoff, e_dis, e_pgl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_uv = 1; m_ov = 0; m_otp = 0; m_hot = 0;
      e_mode = 0; e_boff = 1; e_byoff = 1; e_dis = 1; e_pgl = 1;
    end else begin
      int m; int flt; bit aut; bit pg;
      aut = 0; m = 0;
      if (en_pin) begin
        case (sw_override)
          2'd0: begin m = 1; aut = nbyp_pin && (m_cnt >= Q); end
          2'd1: aut = 1;
          2'd2: m = 1;
          default: m = 0;
        endcase
        if (aut) m = vin_above_target ? 3 : 2;
      end
      flt = m_uv | m_ov | m_otp;
      e_mode  = m;
      e_boff  = (flt != 0 || m != 2) ? 1 : 0;
      e_byoff = (flt != 0 || !(m == 1 || m == 3)) ? 1 : 0;
      e_dis   = en_pin ? 0 : 1;
      if (m == 1) pg = (flt == 0);
      else if (m >= 2) pg = softstart_done && flt == 0 && !valley_oc && m_hot == 0;
      else pg = 0;
      e_pgl = pg ? 0 : 1;
      m_cnt = en_pin ? ((m_cnt < Q) ? m_cnt + 1 : Q) : 0;
      if (vin_below_uv) m_uv = 1; else if (vin_above_uvrel) m_uv = 0;
      if (vin_above_ov) m_ov = 1; else if (vin_below_ovrel) m_ov = 0;
      if (die_temp >= 160) m_otp = 1; else if (die_temp <= 140) m_otp = 0;
      if (die_temp >= 121) m_hot = 1; else if (die_temp <= 99) m_hot = 0;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // R13: compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("mode", int'(mode), e_mode);
      chk("boost_gate_off", int'(boost_gate_off), e_boff);
      chk("bypass_gate_off", int'(bypass_gate_off), e_byoff);
      chk("out_discharge", int'(out_discharge), e_dis);
      chk("pgood_pull_low", int'(pgood_pull_low), e_pgl);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tag = "R12"; wait_cyc(4);
    rst_n = 1; wait_cyc(3);
    tag = "R1";
    nbyp_pin = 1; wait_cyc(5);
    sw_override = 2'd1; wait_cyc(3);
    sw_override = 2'd2; wait_cyc(3);
    sw_override = 2'd0;
    tag = "R6"; vin_above_uvrel = 1; wait_cyc(2); vin_above_uvrel = 0; wait_cyc(2);
    tag = "R2"; en_pin = 1; nbyp_pin = 1; wait_cyc(Q + 6);
    softstart_done = 1; wait_cyc(4);
    tag = "R3"; nbyp_pin = 0; wait_cyc(4); nbyp_pin = 1; wait_cyc(3);
    tag = "R2"; en_pin = 0; wait_cyc(1); en_pin = 1; wait_cyc(Q - 2);
    nbyp_pin = 0; wait_cyc(1); nbyp_pin = 1; wait_cyc(6);
    tag = "R5"; vin_above_target = 1; wait_cyc(4); vin_above_target = 0; wait_cyc(4);
    tag = "R4"; nbyp_pin = 0; sw_override = 2'd1; wait_cyc(4);
    nbyp_pin = 1; sw_override = 2'd2; wait_cyc(4);
    sw_override = 2'd3; wait_cyc(4);
    sw_override = 2'd0; wait_cyc(3);
    tag = "R6"; vin_below_uv = 1; wait_cyc(2); vin_below_uv = 0; wait_cyc(5);
    vin_above_uvrel = 1; vin_below_uv = 1; wait_cyc(2); vin_below_uv = 0; wait_cyc(3);
    vin_above_uvrel = 0; wait_cyc(3);
    tag = "R7"; vin_below_ovrel = 0; vin_above_ov = 1; vin_above_target = 1; wait_cyc(2);
    vin_above_ov = 0; wait_cyc(5); vin_below_ovrel = 1; wait_cyc(4);
    tag = "R8"; die_temp = 8'd150; wait_cyc(4); die_temp = 8'd160; vin_above_target = 0; wait_cyc(4);
    die_temp = 8'd141; wait_cyc(4); die_temp = 8'd140; wait_cyc(4);
    tag = "R10"; die_temp = 8'd121; wait_cyc(4); die_temp = 8'd100; wait_cyc(4);
    die_temp = 8'd99; wait_cyc(4); die_temp = 8'd120; wait_cyc(3);
    valley_oc = 1; wait_cyc(3); valley_oc = 0; wait_cyc(3);
    softstart_done = 0; wait_cyc(3); softstart_done = 1; wait_cyc(3);
    tag = "R11"; nbyp_pin = 0; valley_oc = 1; die_temp = 8'd130; softstart_done = 0; wait_cyc(4);
    vin_below_ovrel = 0; vin_above_ov = 1; wait_cyc(3);
    vin_above_ov = 0; vin_below_ovrel = 1; wait_cyc(3);
    valley_oc = 0; die_temp = 8'd25; softstart_done = 1; nbyp_pin = 1;
    tag = "R9"; sw_override = 2'd1; vin_above_target = 1; wait_cyc(3);
    die_temp = 8'd170; vin_above_target = 0; wait_cyc(3);
    die_temp = 8'd30; sw_override = 2'd2; wait_cyc(4);
    tag = "R1"; en_pin = 0; nbyp_pin = 0; wait_cyc(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule